// File: doc/BRIEF.md
# Double-Data-Rate Output Register

This block turns a pair of parallel bits per lane into one serial stream at twice the clock rate. The bit meant to go first is captured on the rising edge of the primary output clock. The bit meant to go second is also sampled in the primary domain, by an ordinary retiming flop. It then crosses into the complementary clock domain with half a period of budget and is captured there. The complementary clock's rising edge normally falls at the primary clock's falling edge. A phase-driven selector then puts the first register on the output while the primary clock is high, and the second register on the output while it is low.

Logic in the system fabric presents one pair per lane ahead of each primary rising edge. The lane width is a parameter, and every lane has its own pair of registers and its own selector. The block does plain two-edge output registration and has no clock-alignment option. A synchronous active-high reset clears every register.

Top module: `ddr_out_pair`

## Requirements
- R1: `d_first` is sampled only at the primary (`clk_p`) rising edge. A change after that edge does not alter the bit shown during the high phase that follows.
- R2: The complementary register takes the retimed second bit at each `clk_n` rising edge, which is the falling edge of `clk_p` when `clk_n` is the inverse of `clk_p`.
- R3: While `clk_p` is 1, `q_out` equals the first-bit register. While `clk_p` is 0, it equals the complementary register.
- R4: `d_second` is sampled into the retiming flop at the `clk_p` rising edge. A change after that edge does not alter the bit shown during the following low phase.
- R5: A pair presented before `clk_p` rising edge k shows its first bit during the high phase after edge k and its second bit during the low phase right after that. The order is first-then-second, and the latency is the same for every pair in a back-to-back stream.
- R6: When `rst` is 1 at a `clk_p` rising edge, the first-bit register and the retiming flop clear to 0. When `rst` is 1 at a `clk_n` rising edge, the complementary register clears to 0. With `rst` held for a full cycle, `q_out` is 0 in both phases whatever the data inputs are.
- R7: Lanes are independent. Bit i of `q_out` carries only bit i of `d_first` and bit i of `d_second`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary output clock; its rising edge captures both input bits |
| clk_n | input | 1 | Complementary output clock; its rising edge captures the retimed second bit |
| rst | input | 1 | Synchronous active-high reset |
| d_first | input | LANES | Bit sent during the high phase of `clk_p` |
| d_second | input | LANES | Bit sent during the low phase of `clk_p` |
| q_out | output | LANES | Serial double-rate output per lane |

## Verification
Each pair is driven just after a `clk_n` rising edge, so the next `clk_p` rising edge captures it. The first bit is due on `q_out` in the high phase right after that edge. The bench samples it 1 ns after the edge, once the register has settled. The second bit is due one half-period later, after the `clk_n` edge, and the bench samples it 1 ns after the `clk_p` falling edge. Because every pair is checked at these two fixed offsets, a wrong latency, a swapped order or a missing retiming stage appears as a mismatch. Inputs that change 1 ns after a capture edge are checked at the same offsets to show they have no effect.

// File: rtl/ddr_out_pkg.sv
`timescale 1ns/1ps
package ddr_out_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Map the level of the primary clock onto a named phase.
  function automatic phase_e phase_of(input logic clk_level);
    return clk_level ? PH_HIGH : PH_LOW;
  endfunction

  // Choose which registered bit drives the pin in a given phase.
  function automatic logic pick_bit(input phase_e ph, input logic hi_bit, input logic lo_bit);
    return (ph == PH_HIGH) ? hi_bit : lo_bit;
  endfunction

endpackage

// File: rtl/ddr_edge_reg.sv
`timescale 1ns/1ps
module ddr_edge_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/ddr_phase_mux.sv
`timescale 1ns/1ps
module ddr_phase_mux
  import ddr_out_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             sel_clk,
  input  logic [LANES-1:0] hi_v,
  input  logic [LANES-1:0] lo_v,
  output logic [LANES-1:0] y
);

  phase_e ph;
  assign ph = phase_of(sel_clk);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign y[i] = pick_bit(ph, hi_v[i], lo_v[i]);
  end

endmodule

// File: rtl/ddr_out_pair.sv
`timescale 1ns/1ps
module ddr_out_pair #(
  parameter int LANES = 2
) (
  input  logic             clk_p,
  input  logic             clk_n,
  input  logic             rst,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_second,
  output logic [LANES-1:0] q_out
);

  // Named internal stages, brought out for the checker.
  logic [LANES-1:0] first_q;   // primary-domain output register
  logic [LANES-1:0] stage_q;   // primary-domain retiming flop for the second bit
  logic [LANES-1:0] second_q;  // complementary-domain output register

  ddr_edge_reg #(.W(LANES)) u_first (
    .clk (clk_p),
    .rst (rst),
    .d   (d_first),
    .q   (first_q)
  );

  // Half-cycle path: stage_q -> second_q (clk_p rise to clk_n rise).
  ddr_edge_reg #(.W(LANES)) u_retime (
    .clk (clk_p),
    .rst (rst),
    .d   (d_second),
    .q   (stage_q)
  );

  ddr_edge_reg #(.W(LANES)) u_second (
    .clk (clk_n),
    .rst (rst),
    .d   (stage_q),
    .q   (second_q)
  );

  ddr_phase_mux #(.LANES(LANES)) u_mux (
    .sel_clk (clk_p),
    .hi_v    (first_q),
    .lo_v    (second_q),
    .y       (q_out)
  );

endmodule

// File: rtl/ddr_out_pair_chk.sv
`timescale 1ns/1ps
module ddr_out_pair_chk #(
  parameter int LANES = 2
) (
  input logic             clk_p,
  input logic             clk_n,
  input logic             rst,
  input logic [LANES-1:0] d_first,
  input logic [LANES-1:0] d_second,
  input logic [LANES-1:0] first_q,
  input logic [LANES-1:0] stage_q,
  input logic [LANES-1:0] second_q,
  input logic [LANES-1:0] q_out
);

  logic [LANES-1:0] c_first;
  logic [LANES-1:0] c_second;
  logic             armed;
  logic             rst_q;

  always_ff @(posedge clk_p) begin
    c_first  <= d_first;
    c_second <= d_second;
    armed    <= !rst;
    rst_q    <= rst;
  end

  p_first_capture_r1: assert property (@(posedge clk_p) disable iff (rst)
    armed |-> first_q == c_first);

  p_retime_capture_r4: assert property (@(posedge clk_p) disable iff (rst)
    armed |-> stage_q == c_second);

  p_second_capture_r2: assert property (@(posedge clk_n) disable iff (rst)
    (armed && $past(armed)) |-> second_q == $past(stage_q));

  p_high_phase_r3: assert property (@(posedge clk_n) disable iff (rst)
    armed |-> q_out == c_first);

  p_low_phase_r5: assert property (@(posedge clk_p) disable iff (rst)
    armed |-> q_out == c_second);

  p_reset_regs_r6: assert property (@(posedge clk_p)
    rst_q |-> (first_q == '0 && stage_q == '0));

  p_reset_out_r6: assert property (@(posedge clk_n)
    rst_q |-> q_out == '0);

endmodule

bind ddr_out_pair ddr_out_pair_chk #(.LANES(LANES)) u_chk (
  .clk_p    (clk_p),
  .clk_n    (clk_n),
  .rst      (rst),
  .d_first  (d_first),
  .d_second (d_second),
  .first_q  (first_q),
  .stage_q  (stage_q),
  .second_q (second_q),
  .q_out    (q_out)
);

// File: tb/ddr_out_pair_bench.sv
`timescale 1ns/1ps
module ddr_out_pair_bench;
  localparam int L = 2;

  logic         clk_p = 1'b0;
  logic         clk_n;
  logic         rst = 1'b1;
  logic [L-1:0] d_first = '0;
  logic [L-1:0] d_second = '0;
  logic [L-1:0] q_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign clk_n = ~clk_p;
  always #2 clk_p = ~clk_p;

  ddr_out_pair #(.LANES(L)) u_ddr_out_pair (
    .clk_p(clk_p), .clk_n(clk_n), .rst(rst),
    .d_first(d_first), .d_second(d_second), .q_out(q_out)
  );

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One primary cycle: present a pair, check the high then the low phase.
  task automatic push_pair(input logic [L-1:0] f, input logic [L-1:0] s, input string req);
    d_first = f; d_second = s;
    @(posedge clk_p); #1;
    chk({req, " high phase"}, q_out, f);
    @(negedge clk_p); #1;
    chk({req, " low phase"}, q_out, s);
  endtask

  task automatic test_reset_hold();
    rst = 1'b1; d_first = '1; d_second = '1;
    repeat (3) @(posedge clk_p);
    #1 chk("R6 reset high phase", q_out, '0);
    @(negedge clk_p); #1 chk("R6 reset low phase", q_out, '0);
    @(posedge clk_p); #1 rst = 1'b0;
    @(negedge clk_p); #1;
  endtask

  task automatic test_alternating();
    push_pair(2'b11, 2'b00, "R3");
    push_pair(2'b00, 2'b11, "R3");
    push_pair(2'b10, 2'b01, "R2");
    push_pair(2'b01, 2'b10, "R2");
  endtask

  task automatic test_counting_stream();
    for (int i = 0; i < 16; i++) begin
      logic [L-1:0] f = 2'(2 * i);
      logic [L-1:0] s = 2'(2 * i + 1);
      push_pair(f, s, "R5 stream");
    end
  endtask

  task automatic test_lanes();
    push_pair(2'b01, 2'b01, "R7 lane0 only");
    push_pair(2'b10, 2'b10, "R7 lane1 only");
    push_pair(2'b01, 2'b10, "R7 crossed");
    push_pair(2'b11, 2'b11, "R7 both");
  endtask

  task automatic test_late_change();
    d_first = 2'b10; d_second = 2'b01;
    @(posedge clk_p); #1;
    d_first = 2'b01; d_second = 2'b10;
    chk("R1 late first change", q_out, 2'b10);
    @(negedge clk_p); #1;
    chk("R4 late second change", q_out, 2'b01);
    push_pair(2'b00, 2'b00, "R4 after");
  endtask

  task automatic test_mid_reset();
    push_pair(2'b11, 2'b11, "R6 before");
    d_first = 2'b11; d_second = 2'b11;
    rst = 1'b1;
    @(posedge clk_p); #1 chk("R6 mid high", q_out, '0);
    @(negedge clk_p); #1 chk("R6 mid low", q_out, '0);
    rst = 1'b0;
    push_pair(2'b01, 2'b11, "R6 recover");
  endtask

  initial begin
    test_reset_hold();
    test_alternating();
    test_counting_stream();
    test_lanes();
    test_late_change();
    test_mid_reset();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule